// File: doc/BRIEF.md
# Image Row Zero-Bias Corrector

This block removes per-row dark offset from a captured image. An external sensor streams 8-bit samples, one per strobe, row after row. Each row has 66 samples: 64 light-exposed pixels first, then 2 samples from columns that are shielded from light. Any non-zero value read from the shielded columns is offset error that is shared by the whole row. The block keeps the 64 pixels of the row in a frame store and takes the mean of the two shielded samples as the row's bias. It then walks the stored row, overwriting each pixel with the pixel minus the bias, and only after that accepts the next row.

A one-cycle start pulse begins a capture of 64 rows. While the block is storing a row it raises a ready output, so the sensor side knows when strobes are taken. After the last row has been corrected a done flag rises and stays high until the next start. A host then reads the corrected 64x64 image one pixel per read strobe, in row-major order, through a read port with an auto-incrementing index.

Top module: `zbias_corrector`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `done`, `pix_ready` and `rd_data` are 0.
- R2: A `start` pulse in the idle state makes `pix_ready` high and `done` low from the following cycle on.
- R3: In a row, the first 64 accepted strobes are the pixels for columns 0 to 63 and the next 2 are the shielded reference samples; the image is stored row by row, row 0 first.
- R4: The row bias treats both reference samples as signed two's-complement bytes and equals their sum divided by 2, rounded toward zero (for example -3 and 0 give -1, 0x80 and 0x80 give -128).
- R5: Each stored pixel is replaced by (pixel - bias) modulo 256, with no saturation.
- R6: After the 66th accepted strobe of a row that is not the last, `pix_ready` is low for exactly 66 cycles (one bias cycle, 64 correction cycles, one row-advance cycle), then high again.
- R7: Strobes on `pix_valid` while `pix_ready` is low (idle or during correction) are ignored and do not change the stored image.
- R8: `done` rises 67 cycles after the last strobe of row 63, then stays high until the next accepted `start`; a `start` during a capture is ignored.
- R9: Each cycle with `rd_en` high loads `rd_data` in the next cycle with the pixel at the read index and advances the index; the index wraps from 4095 to 0 and an accepted `start` sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a capture when idle |
| pix_valid | input | 1 | Sensor sample strobe |
| pix_data | input | 8 | Sensor sample value |
| pix_ready | output | 1 | High while a row is being taken in |
| done | output | 1 | High from capture completion until the next start |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Corrected pixel, valid the cycle after `rd_en` |

## Verification
The correction is tried with hand-picked reference pairs that separate rounding toward zero from flooring (odd negative sums), that hit the signed extremes (-128 and 127 bias), and with flat rows of 0x00, 0x7F and 0xFF where only the wrap of the subtraction decides the result; the remaining rows carry random pixels and references from a fixed seed. Junk strobes fed during a correction pass and while idle, and a start pulse in the middle of a capture, tell a design that gates its inputs by state from one that does not. A second capture without reset, after a partial readout, shows that start reloads the read index and clears done.

// File: rtl/zbc_pkg.sv
package zbc_pkg;
  // number of shielded reference samples at the end of each row
  localparam int ZB_REFS = 2;

  typedef enum logic [2:0] {
    ZS_IDLE,
    ZS_GET,
    ZS_BIAS,
    ZS_FIX,
    ZS_NEXT
  } zb_state_e;
endpackage

// File: rtl/zbc_row_seq.sv
module zbc_row_seq
  import zbc_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  localparam int LINE = COLS + ZB_REFS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = $clog2(LINE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pix_valid,
  output logic [RW-1:0] row_q,
  output logic [CW-1:0] col_q,
  output logic          cap_we,
  output logic          ref_we,
  output logic          ref_sel,
  output logic          bias_load,
  output logic          fix_we,
  output logic          start_acc,
  output logic          pix_ready,
  output logic          done
);
  localparam logic [CW-1:0] LAST_COL = CW'(LINE - 1);
  localparam logic [CW-1:0] FIRST_REF = CW'(COLS);
  localparam logic [CW-1:0] LAST_PIX = CW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  zb_state_e st_q;
  logic      row_full;

  // named events for the datapath and the assertions
  assign pix_ready = (st_q == ZS_GET);
  assign start_acc = (st_q == ZS_IDLE) && start;
  assign cap_we    = pix_ready && pix_valid && (col_q < FIRST_REF);
  assign ref_we    = pix_ready && pix_valid && (col_q >= FIRST_REF);
  assign ref_sel   = (col_q == FIRST_REF) ? 1'b0 : 1'b1;
  assign row_full  = pix_ready && pix_valid && (col_q == LAST_COL);
  assign bias_load = (st_q == ZS_BIAS);
  assign fix_we    = (st_q == ZS_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ZS_IDLE;
      row_q <= '0;
      col_q <= '0;
      done  <= 1'b0;
    end else begin
      case (st_q)
        ZS_IDLE: begin
          if (start) begin
            st_q  <= ZS_GET;
            row_q <= '0;
            col_q <= '0;
            done  <= 1'b0;
          end
        end
        ZS_GET: begin
          if (pix_valid) begin
            if (col_q == LAST_COL) begin
              col_q <= '0;
              st_q  <= ZS_BIAS;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
        end
        ZS_BIAS: begin
          st_q <= ZS_FIX;
        end
        ZS_FIX: begin
          if (col_q == LAST_PIX) begin
            col_q <= '0;
            st_q  <= ZS_NEXT;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ZS_NEXT: begin
          col_q <= '0;
          if (row_q == LAST_ROW) begin
            row_q <= '0;
            done  <= 1'b1;
            st_q  <= ZS_IDLE;
          end else begin
            row_q <= row_q + 1'b1;
            st_q  <= ZS_GET;
          end
        end
        default: st_q <= ZS_IDLE;
      endcase
    end
  end

  // R2: an accepted start opens row capture and drops done
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (pix_ready && !done));

  // R3: the column index never leaves the row
  p_col_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_COL);

  // R6: a full row closes the intake at once
  p_row_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_full |=> (!pix_ready && bias_load));

  // R5: the correction pass follows the bias cycle
  p_fix_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bias_load |=> fix_we);

  // R8: done holds until a start is taken
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/zbc_bias_unit.sv
module zbc_bias_unit #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_we,
  input  logic          ref_sel,
  input  logic [PW-1:0] pix_in,
  input  logic          bias_load,
  input  logic [PW-1:0] raw_pix,
  output logic [PW-1:0] bias_q,
  output logic [PW-1:0] fixed_pix
);
  logic [PW-1:0] ref_a_q;
  logic [PW-1:0] ref_b_q;

  // signed mean of two samples, rounded toward zero
  function automatic logic [PW-1:0] mean_to_zero(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW:0] s;
    s = {a[PW-1], a} + {b[PW-1], b};
    if (s[PW] && s[0]) s = s + 1'b1;
    return s[PW:1];
  endfunction

  // pixel minus bias, wrapping at the byte width
  function automatic logic [PW-1:0] remove_bias(input logic [PW-1:0] p, input logic [PW-1:0] b);
    return p - b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a_q <= '0;
      ref_b_q <= '0;
      bias_q  <= '0;
    end else begin
      if (ref_we && !ref_sel) ref_a_q <= pix_in;
      if (ref_we && ref_sel)  ref_b_q <= pix_in;
      if (bias_load)          bias_q  <= mean_to_zero(ref_a_q, ref_b_q);
    end
  end

  assign fixed_pix = remove_bias(raw_pix, bias_q);

  // R4: the bias lies between the two reference samples
  p_bias_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bias_load |=>
      ((($signed(bias_q) <= $signed($past(ref_a_q))) || ($signed(bias_q) <= $signed($past(ref_b_q)))) &&
       (($signed(bias_q) >= $signed($past(ref_a_q))) || ($signed(bias_q) >= $signed($past(ref_b_q))))));
endmodule

// File: rtl/zbc_frame_store.sv
module zbc_frame_store #(
  parameter int PW = 8,
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr_a,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata_a,
  input  logic          rd_en,
  input  logic [AW-1:0] addr_b,
  output logic [PW-1:0] rdata_b
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr_a] <= wdata;
  end

  // read-modify-write port for the correction pass
  assign rdata_a = mem[addr_a];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_b <= '0;
    else if (rd_en) rdata_b <= mem[addr_b];
  end
endmodule

// File: rtl/zbc_host_reader.sv
module zbc_host_reader #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          rd_en,
  output logic [AW-1:0] idx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (restart) idx_q <= '0;
    else if (rd_en)   idx_q <= idx_q + 1'b1;
  end

  // R9: a start returns the read index to the first pixel
  p_idx_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (idx_q == '0));

  // R9: an idle host leaves the index in place
  p_idx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !restart) |=> $stable(idx_q));
endmodule

// File: rtl/zbias_corrector.sv
module zbias_corrector
  import zbc_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_data,
  output logic          pix_ready,
  output logic          done,
  input  logic          rd_en,
  output logic [PW-1:0] rd_data
);
  localparam int DEPTH = ROWS * COLS;
  localparam int AW = $clog2(DEPTH);
  localparam int LINE = COLS + ZB_REFS;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = $clog2(LINE);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          cap_we, ref_we, ref_sel, bias_load, fix_we, start_acc;
  logic [PW-1:0] bias_q, raw_pix, fixed_pix, wdata;
  logic [AW-1:0] addr_a, rd_idx;
  logic          we;

  zbc_row_seq #(.ROWS(ROWS), .COLS(COLS)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
    .row_q(row_q), .col_q(col_q), .cap_we(cap_we), .ref_we(ref_we),
    .ref_sel(ref_sel), .bias_load(bias_load), .fix_we(fix_we),
    .start_acc(start_acc), .pix_ready(pix_ready), .done(done)
  );

  zbc_bias_unit #(.PW(PW)) i_bias (
    .clk(clk), .rst_n(rst_n), .ref_we(ref_we), .ref_sel(ref_sel),
    .pix_in(pix_data), .bias_load(bias_load), .raw_pix(raw_pix),
    .bias_q(bias_q), .fixed_pix(fixed_pix)
  );

  assign addr_a = AW'(row_q) * AW'(COLS) + AW'(col_q);
  assign we     = cap_we || fix_we;
  assign wdata  = cap_we ? pix_data : fixed_pix;

  zbc_frame_store #(.PW(PW), .DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .we(we), .addr_a(addr_a), .wdata(wdata),
    .rdata_a(raw_pix), .rd_en(rd_en), .addr_b(rd_idx), .rdata_b(rd_data)
  );

  zbc_host_reader #(.AW(AW)) i_host (
    .clk(clk), .rst_n(rst_n), .restart(start_acc), .rd_en(rd_en), .idx_q(rd_idx)
  );

  // R7: capture and correction never write in the same cycle
  p_one_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_we, fix_we}));

  // R7: nothing is written while intake is closed and no pass runs
  p_closed_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ready && !fix_we) |-> !we);
endmodule

// File: tb/test_zbias_corrector.sv
module test_zbias_corrector;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int LINE = 66;
  localparam int NPIX = ROWS * COLS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, start, pix_valid, rd_en;
  logic [7:0] pix_data;
  wire        pix_ready, done;
  wire  [7:0] rd_data;

  logic [7:0] img [ROWS][LINE];
  logic [7:0] expv [NPIX];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  zbias_corrector i_zbias_corrector (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .done(done),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // signed mean, integer division truncates toward zero
  function automatic int model_bias(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'($signed(a)) + int'($signed(b));
    return s / 2;
  endfunction

  function automatic logic [7:0] model_fix(input logic [7:0] p, input int bias);
    int d;
    d = int'(p) - bias;
    return 8'(d);
  endfunction

  task automatic make_image(input bit directed);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < LINE; c++) img[r][c] = 8'($urandom);
    if (directed) begin
      img[0][64] = 8'hFD; img[0][65] = 8'h00; img[0][0] = 8'h10;
      img[1][64] = 8'h7F; img[1][65] = 8'h7F;
      img[2][64] = 8'h80; img[2][65] = 8'h80;
      for (int c = 0; c < COLS; c++) img[2][c] = 8'h7F;
      img[3][64] = 8'hFF; img[3][65] = 8'hFE;
      img[4][64] = 8'h05; img[4][65] = 8'h06; img[4][0] = 8'h80;
      img[5][64] = 8'h03; img[5][65] = 8'h04;
      for (int c = 0; c < COLS; c++) img[5][c] = 8'h00;
      img[6][64] = 8'h80; img[6][65] = 8'h7F;
      for (int c = 0; c < COLS; c++) img[6][c] = 8'hFF;
      img[7][64] = 8'h01; img[7][65] = 8'h00;
    end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        expv[r*COLS+c] = model_fix(img[r][c], model_bias(img[r][64], img[r][65]));
  endtask

  // called at a negedge with pix_ready high
  task automatic send_row(input int r, input bit junk, input bit poke);
    int gap;
    for (int c = 0; c < LINE; c++) begin
      pix_valid = 1'b1;
      pix_data = img[r][c];
      if (poke && c == 10) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    pix_valid = junk;
    pix_data = 8'hAA;
    if (r < ROWS - 1) begin
      gap = 0;
      while (!pix_ready && gap < 200) begin
        gap++;
        @(negedge clk);
      end
      chk(gap == 66, "R6 ready gap", gap, 66);
    end else begin
      for (int k = 0; k < 66; k++) begin
        if (k == 65) chk(done == 1'b0, "R8 done early", done, 0);
        @(negedge clk);
      end
      pix_valid = 1'b0;
      chk(done == 1'b1, "R8 done rises", done, 1);
    end
  endtask

  task automatic capture(input bit directed);
    make_image(directed);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(pix_ready == 1'b1, "R2 ready after start", pix_ready, 1);
    chk(done == 1'b0, "R2 done cleared", done, 0);
    for (int r = 0; r < ROWS; r++) send_row(r, (r == 10), (r == 20));
  endtask

  task automatic read_all();
    for (int i = 0; i < NPIX; i++) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (i < 8 * COLS)
        chk(rd_data == expv[i], "R4 directed bias", rd_data, expv[i]);
      else if (i % COLS == COLS - 1)
        chk(rd_data == expv[i], "R3 row order", rd_data, expv[i]);
      else
        chk(rd_data == expv[i], "R5 corrected pixel", rd_data, expv[i]);
      if ($urandom % 8 == 0) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; pix_valid = 1'b0; rd_en = 1'b0; pix_data = 8'h00;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(pix_ready == 1'b0, "R1 ready in reset", pix_ready, 0);
    chk(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && pix_ready == 1'b0, "R1 idle after reset", {done, pix_ready}, 0);

    // R7: idle strobes are not taken
    pix_valid = 1'b1; pix_data = 8'h55;
    repeat (3) @(negedge clk);
    pix_valid = 1'b0;
    chk(pix_ready == 1'b0, "R7 idle ignores strobes", pix_ready, 0);

    capture(1'b1);
    // R8: done holds; R7: idle strobes leave the image intact
    pix_valid = 1'b1; pix_data = 8'h33;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(done == 1'b1, "R8 done holds", done, 1);
    end
    pix_valid = 1'b0;

    // directed values computed by hand
    chk(model_bias(8'hFD, 8'h00) == -1, "R4 bench model", model_bias(8'hFD, 8'h00), -1);
    read_all();
    // R9: index wraps to the first pixel
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == expv[0], "R9 index wrap", rd_data, expv[0]);
    chk(expv[0] == 8'h11, "R4 rounds toward zero", expv[0], 8'h11);
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;

    // second capture: start reloads index and clears done
    capture(1'b0);
    read_all();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule